// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This unit watches a bank of already synchronised general-purpose input pins and turns activity on them into interrupt requests. Every pin is given its own trigger condition: a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets a sticky pending bit for that pin. Software can read the pending bits, acknowledge them one at a time and enable or mask each pin.

Pins are grouped into two halves, and each half drives its own interrupt line. Each line is the OR of the pending-and-enabled bits in its half. An accept gate sits in front of the pending bits, so a pin can be shut off at the source while its trigger mode is being changed.

Software reaches the unit through a plain 32-bit register port. It has a write strobe, a read strobe and a byte address. Read data is registered. The trigger settings live in a second window at byte offset 0x40.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, all enable, accept, trigger and pending bits are zero, both interrupt lines are low, and every readable register returns zero.
- R2: Writing to offset 0x18 sets the enable bits where the data holds 1s. Writing to offset 0x1C clears the enable bits where the data holds 1s. Reading either offset returns the enable bits.
- R3: Offset 0x14 is a read/write accept register with bit n for pin n. While bit n is 0, pin n sets no new pending status.
- R4: Pin n takes its trigger code from the register at 0x40 + 4*floor(n/8), in bits 4*(n mod 8)+3 down to 4*(n mod 8). These registers read back exactly what was written.
- R5: Code 0 catches a rising edge and code 1 catches a falling edge. An edge is the synchronised input differing from its value in the previous cycle. Edge pending status stays set after the pin returns to its old level, until it is acknowledged.
- R6: Code 2 (high level) and code 3 (low level) keep pending status set for as long as the level is active, even through an acknowledge. Once the level is inactive, an acknowledge clears the bit.
- R7: Code 4 catches both edges. Detection decodes only bits 2:0 of a code, so bit 3 is a free flag that changes nothing (code 12 acts as 4). Codes 5 to 7 never raise an event.
- R8: Writing 1s to offset 0x28 clears the matching pending bits. When an event and an acknowledge of the same pin fall in the same cycle, the pin stays pending.
- R9: Offset 0x20 returns the raw pending bits. Offset 0x24 returns the pending bits ANDed with the enable bits.
- R10: `irq_lo` is the OR of the masked bits of pins 0 to 15 and `irq_hi` is the OR for pins 16 to 31. Each is registered and follows the pending and enable state one cycle later.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe. Unmapped offsets and the write-only acknowledge offset read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pins_in | input | 32 | Synchronised GPIO input levels |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
The bench builds the unit with its default values: 32 pins and eight 4-bit trigger fields per register. With these values both interrupt halves are exercised, and all four trigger registers, each field position and the window boundary at 0x50 can be reached. At this width, pins picked in different registers and halves show that the field layout and the low/high split line up with the pin index.

// File: rtl/gis_pkg.sv
package gis_pkg;

  typedef enum logic [2:0] {
    TRIG_RISE = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_HIGH = 3'd2,
    TRIG_LOW  = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam int OFS_ACCEPT     = 'h14;
  localparam int OFS_EN_SET     = 'h18;
  localparam int OFS_EN_CLR     = 'h1C;
  localparam int OFS_RAW        = 'h20;
  localparam int OFS_MASKED     = 'h24;
  localparam int OFS_ACK        = 'h28;
  localparam int OFS_TRIG_BASE  = 'h40;

endpackage

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
#(
  parameter int NUM_PINS     = 32,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int CODE_W       = 4,
  parameter int PINS_PER_REG = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [NUM_PINS-1:0]        raw_pend,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_PINS-1:0]        accept,
  output logic [NUM_PINS-1:0]        enable,
  output logic [NUM_PINS*CODE_W-1:0] trig_flat,
  output logic [NUM_PINS-1:0]        ack_mask
);

  localparam int NUM_TRIG_REGS = NUM_PINS / PINS_PER_REG;
  localparam int REG_BITS      = PINS_PER_REG * CODE_W;

  logic [NUM_PINS-1:0] wdata_pins;
  logic                hit_accept, hit_set, hit_clr, hit_ack;
  logic [DATA_W-1:0]   rd_next;

  assign wdata_pins = bus_wdata[NUM_PINS-1:0];
  assign hit_accept = bus_wr && (bus_addr == ADDR_W'(OFS_ACCEPT));
  assign hit_set    = bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET));
  assign hit_clr    = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign hit_ack    = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
  assign ack_mask   = hit_ack ? wdata_pins : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept <= '0;
      enable <= '0;
    end else begin
      if (hit_accept) accept <= wdata_pins;
      if (hit_set)    enable <= enable | wdata_pins;
      else if (hit_clr) enable <= enable & ~wdata_pins;
    end
  end

  // one trigger register per group of pins
  for (genvar r = 0; r < NUM_TRIG_REGS; r++) begin : g_trig
    always_ff @(posedge clk) begin
      if (rst)
        trig_flat[r*REG_BITS +: REG_BITS] <= '0;
      else if (bus_wr && (bus_addr == ADDR_W'(OFS_TRIG_BASE + 4*r)))
        trig_flat[r*REG_BITS +: REG_BITS] <= bus_wdata[REG_BITS-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(OFS_ACCEPT)) rd_next = DATA_W'(accept);
    if (bus_addr == ADDR_W'(OFS_EN_SET)) rd_next = DATA_W'(enable);
    if (bus_addr == ADDR_W'(OFS_EN_CLR)) rd_next = DATA_W'(enable);
    if (bus_addr == ADDR_W'(OFS_RAW))    rd_next = DATA_W'(raw_pend);
    if (bus_addr == ADDR_W'(OFS_MASKED)) rd_next = DATA_W'(raw_pend & enable);
    for (int r = 0; r < NUM_TRIG_REGS; r++)
      if (bus_addr == ADDR_W'(OFS_TRIG_BASE + 4*r))
        rd_next = DATA_W'(trig_flat[r*REG_BITS +: REG_BITS]);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R2: a set write leaves every selected enable bit at 1
  a_r2_enable_set: assert property (@(posedge clk) disable iff (rst)
    hit_set |=> ((enable & $past(wdata_pins)) == $past(wdata_pins)));

  // R2: a clear write leaves every selected enable bit at 0
  a_r2_enable_clr: assert property (@(posedge clk) disable iff (rst)
    hit_clr |=> ((enable & $past(wdata_pins)) == '0));

  // R3: the accept register holds what was written
  a_r3_accept_wr: assert property (@(posedge clk) disable iff (rst)
    hit_accept |=> (accept == $past(wdata_pins)));

endmodule

// File: rtl/gis_detect.sv
module gis_detect
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CODE_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        pins_in,
  input  logic [NUM_PINS*CODE_W-1:0] trig_flat,
  input  logic [NUM_PINS-1:0]        accept,
  output logic [NUM_PINS-1:0]        event_vec
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pins_in;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic [2:0] mode;
    logic       hit;
    assign mode = trig_flat[n*CODE_W +: 3];
    always_comb begin
      case (mode)
        TRIG_RISE: hit =  pins_in[n] & ~prev_q[n];
        TRIG_FALL: hit = ~pins_in[n] &  prev_q[n];
        TRIG_HIGH: hit =  pins_in[n];
        TRIG_LOW:  hit = ~pins_in[n];
        TRIG_BOTH: hit =  pins_in[n] ^  prev_q[n];
        default:   hit = 1'b0;
      endcase
    end
    assign event_vec[n] = hit & accept[n];
  end

  // R5: the stored copy tracks the input one cycle late
  a_r5_prev_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev_q == $past(pins_in)));

endmodule

// File: rtl/gis_status.sv
module gis_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] event_vec,
  input  logic [NUM_PINS-1:0] ack_mask,
  input  logic [NUM_PINS-1:0] enable,
  output logic [NUM_PINS-1:0] raw_pend,
  output logic                irq_lo,
  output logic                irq_hi
);

  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] masked;
  assign masked = raw_pend & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_pend <= '0;
      irq_lo   <= 1'b0;
      irq_hi   <= 1'b0;
    end else begin
      raw_pend <= (raw_pend & ~ack_mask) | event_vec;
      irq_lo   <= |masked[HALF-1:0];
      irq_hi   <= |masked[NUM_PINS-1:HALF];
    end
  end

  // R8: acknowledged bits with no new event are cleared
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (|ack_mask) |=> ((raw_pend & $past(ack_mask & ~event_vec)) == '0));

  // R8: an event always leaves its bit pending, acknowledge or not
  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|event_vec) |=> ((raw_pend & $past(event_vec)) == $past(event_vec)));

  // R10: low line follows the masked low half one cycle later
  a_r10_irq_lo: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_lo == $past(|(raw_pend[HALF-1:0] & enable[HALF-1:0]))));

  // R10: high line follows the masked high half one cycle later
  a_r10_irq_hi: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_hi == $past(|(raw_pend[NUM_PINS-1:HALF] & enable[NUM_PINS-1:HALF]))));

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int NUM_PINS     = 32,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int CODE_W       = 4,
  parameter int PINS_PER_REG = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic                irq_lo,
  output logic                irq_hi
);

  logic [NUM_PINS-1:0]        accept, enable, ack_mask, event_vec, raw_pend;
  logic [NUM_PINS*CODE_W-1:0] trig_flat;

  gis_regs #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CODE_W(CODE_W), .PINS_PER_REG(PINS_PER_REG)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_pend(raw_pend),
    .bus_rdata(bus_rdata), .accept(accept), .enable(enable),
    .trig_flat(trig_flat), .ack_mask(ack_mask)
  );

  gis_detect #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) u_detect (
    .clk(clk), .rst(rst), .pins_in(pins_in), .trig_flat(trig_flat),
    .accept(accept), .event_vec(event_vec)
  );

  gis_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk(clk), .rst(rst), .event_vec(event_vec), .ack_mask(ack_mask),
    .enable(enable), .raw_pend(raw_pend), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // R3: a pending bit can only rise where the accept bit was set
  a_r3_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_pend & ~$past(raw_pend) & ~$past(accept)) == '0));

endmodule

// File: tb/gpio_irq_sense_tb.sv
module gpio_irq_sense_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic        irq_lo, irq_hi;

  int tests = 0;
  int fails = 0;
  logic [31:0] trig_sh [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_sense dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(tag, v, exp);
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk); pins[idx] = v;
    @(negedge clk);
  endtask

  task automatic set_trig(input int pin, input logic [3:0] code);
    trig_sh[pin/8][4*(pin%8) +: 4] = code;
    bus_write(8'(8'h40 + 4*(pin/8)), trig_sh[pin/8]);
  endtask

  task automatic t_reset;
    rd_chk("R1 accept", 8'h14, 0);
    rd_chk("R1 enable", 8'h18, 0);
    rd_chk("R1 raw", 8'h20, 0);
    rd_chk("R1 masked", 8'h24, 0);
    for (int r = 0; r < 4; r++) rd_chk("R1 trig", 8'(8'h40 + 4*r), 0);
    chk("R1 irq_lo", 32'(irq_lo), 0);
    chk("R1 irq_hi", 32'(irq_hi), 0);
  endtask

  task automatic t_enable;
    bus_write(8'h18, 32'hF0F0_00FF);
    rd_chk("R2 set", 8'h18, 32'hF0F0_00FF);
    bus_write(8'h18, 32'h0000_0100);
    rd_chk("R2 set accumulates", 8'h18, 32'hF0F0_01FF);
    bus_write(8'h1C, 32'h0000_010F);
    rd_chk("R2 clear", 8'h1C, 32'hF0F0_00F0);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    rd_chk("R2 clear all", 8'h18, 0);
  endtask

  task automatic t_layout;
    bus_write(8'h44, 32'h1234_5678);
    bus_write(8'h4C, 32'h4C4C_4C4C);
    rd_chk("R4 readback 0x44", 8'h44, 32'h1234_5678);
    rd_chk("R4 readback 0x4C", 8'h4C, 32'h4C4C_4C4C);
    rd_chk("R4 untouched 0x48", 8'h48, 0);
    for (int r = 0; r < 4; r++) begin
      bus_write(8'(8'h40 + 4*r), 0);
      trig_sh[r] = 0;
    end
    set_trig(9, 4'h1);
    rd_chk("R4 pin9 field", 8'h44, 32'h0000_0010);
    set_trig(9, 4'h0);
  endtask

  task automatic t_accept;
    set_trig(3, 4'h0);
    set_pin(3, 1'b1);
    rd_chk("R3 gated edge ignored", 8'h20, 0);
    set_pin(3, 1'b0);
    bus_write(8'h14, 32'h8000_0001);
    rd_chk("R3 accept readback", 8'h14, 32'h8000_0001);
    bus_write(8'h14, 0);
    rd_chk("R3 still no pending", 8'h20, 0);
  endtask

  task automatic t_edges;
    set_trig(9, 4'h0);
    set_trig(20, 4'h1);
    bus_write(8'h14, (32'd1 << 9) | (32'd1 << 20));
    set_pin(9, 1'b1);
    set_pin(20, 1'b1);
    rd_chk("R5 rising caught, fall mode quiet", 8'h20, 32'd1 << 9);
    set_pin(9, 1'b0);
    rd_chk("R5 edge pending sticky", 8'h20, 32'd1 << 9);
    set_pin(20, 1'b0);
    rd_chk("R5 falling caught", 8'h20, (32'd1 << 9) | (32'd1 << 20));
    bus_write(8'h28, 32'd1 << 9);
    rd_chk("R8 ack clears one", 8'h20, 32'd1 << 20);
    rd_chk("R11 ack offset reads zero", 8'h28, 0);
    bus_write(8'h28, 32'hFFFF_FFFF);
    rd_chk("R8 ack clears all", 8'h20, 0);
    bus_write(8'h14, 0);
  endtask

  task automatic t_level;
    set_trig(5, 4'h2);
    set_trig(27, 4'h3);
    bus_write(8'h14, (32'd1 << 5) | (32'd1 << 27));
    set_pin(5, 1'b1);
    rd_chk("R6 both levels pending", 8'h20, (32'd1 << 5) | (32'd1 << 27));
    bus_write(8'h28, (32'd1 << 5) | (32'd1 << 27));
    rd_chk("R6 active level survives ack", 8'h20, (32'd1 << 5) | (32'd1 << 27));
    set_pin(5, 1'b0);
    set_pin(27, 1'b1);
    bus_write(8'h28, (32'd1 << 5) | (32'd1 << 27));
    rd_chk("R6 inactive level acked", 8'h20, 0);
    bus_write(8'h14, 0);
    set_trig(5, 4'h0);
    set_trig(27, 4'h0);
  endtask

  task automatic t_both;
    set_trig(12, 4'h4);
    set_trig(13, 4'h5);
    set_trig(14, 4'hC);
    bus_write(8'h14, 32'h0000_7000);
    @(negedge clk); pins[14:12] = 3'b111;
    @(negedge clk);
    rd_chk("R7 rise both-edge, code5 quiet", 8'h20, 32'h0000_5000);
    bus_write(8'h28, 32'hFFFF_FFFF);
    @(negedge clk); pins[14:12] = 3'b000;
    @(negedge clk);
    rd_chk("R7 fall both-edge, flag ignored", 8'h20, 32'h0000_5000);
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_write(8'h14, 0);
  endtask

  task automatic t_race;
    set_trig(9, 4'h0);
    bus_write(8'h14, 32'd1 << 9);
    @(negedge clk);
    pins[9] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'd1 << 9;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk("R8 event beats ack", 8'h20, 32'd1 << 9);
    bus_write(8'h28, 32'd1 << 9);
    rd_chk("R8 then cleared", 8'h20, 0);
    set_pin(9, 1'b0);
    bus_write(8'h14, 0);
  endtask

  task automatic t_irq;
    set_trig(20, 4'h0);
    bus_write(8'h18, 32'd1 << 20);
    bus_write(8'h14, (32'd1 << 9) | (32'd1 << 20));
    @(negedge clk); pins[9] = 1'b1; pins[20] = 1'b1;
    @(negedge clk);
    chk("R10 irq_hi one cycle late", 32'(irq_hi), 0);
    @(negedge clk);
    chk("R10 irq_hi raised", 32'(irq_hi), 1);
    chk("R10 irq_lo masked off", 32'(irq_lo), 0);
    rd_chk("R9 masked", 8'h24, 32'd1 << 20);
    rd_chk("R9 raw", 8'h20, (32'd1 << 9) | (32'd1 << 20));
    bus_write(8'h18, 32'd1 << 9);
    @(negedge clk);
    chk("R10 irq_lo after enable", 32'(irq_lo), 1);
    bus_write(8'h28, 32'd1 << 20);
    @(negedge clk);
    chk("R10 irq_hi after ack", 32'(irq_hi), 0);
    chk("R10 irq_lo kept", 32'(irq_lo), 1);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 irq_lo after disable", 32'(irq_lo), 0);
    rd_chk("R9 masked empty, raw kept", 8'h24, 0);
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_write(8'h14, 0);
  endtask

  task automatic t_unmapped;
    rd_chk("R11 hole 0x30", 8'h30, 0);
    rd_chk("R11 past window 0x50", 8'h50, 0);
    rd_chk("R11 hole 0x00", 8'h00, 0);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) trig_sh[r] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_layout();
    t_accept();
    t_edges();
    t_level();
    t_both();
    t_race();
    t_irq();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule